// File: doc/BRIEF.md
# Logical Device Activation and I/O Range-Check Responder

This block holds the per-logical-device configuration state of an expansion card. That state is an activation bit, a range-check control, a set of 16-bit I/O base addresses, interrupt level and trigger entries, and DMA channel selectors. The host programs these through an 8-bit indexed configuration port. Every register can be read back through the same port.

The block also watches system-bus I/O reads. When range check is enabled and the device is not active, a read that falls inside one of the programmed I/O windows is answered with a fixed test byte. The byte is either 0x55 or 0xAA, as chosen by software. The host uses this answer to find address conflicts before it turns the device on.

A device-level reset pulse returns every register to its power-up value.

Top module: `ldev_iochk`

## Requirements
- R1: After reset, the registers hold these values: activation 0, range-check control 0, all I/O bases 0x0000, interrupt levels 0, trigger bytes 0x02, DMA selectors 4. With these values, `dev_active`, `bus_drive` and `bus_rdata` are all 0.
- R2: Index 0x30 holds the activation flag in bit 0. A write updates `dev_active` at the next clock edge. Reads return 0 in bits [7:1].
- R3: Index 0x31 holds the range-check enable in bit 1 and the pattern select in bit 0. Reads return 0 in bits [7:2].
- R4: The base of I/O window i sits at index 0x60+2i for bits [15:8] and at 0x61+2i for bits [7:0]. Both bytes read back as written.
- R5: Interrupt entry j stores a 4-bit level at index 0x70+2j and a 2-bit trigger field at 0x71+2j. In the trigger field, bit 1 is polarity and bit 0 is level/edge. Unused upper bits read 0.
- R6: DMA selector k is at index 0x74+k and stores bits [2:0]. Upper bits read 0. The value 4 means no channel is in use.
- R7: A bus read hits window i when base ≤ address < base + span(i) and the base is non-zero. The default span is 8. When a read hits, range check is enabled and the device is inactive, `bus_drive` is 1 in the cycle after the read. In that cycle `bus_rdata` is 0x55 if the pattern select bit is 1, or 0xAA if it is 0. In every other cycle, `bus_rdata` is 0.
- R8: No test byte is driven while the device is active, while range check is disabled, or for an address outside every window.
- R9: `cfg_rdata` takes the value of the indexed register in the cycle after `cfg_rd` and holds it until the next read. Indices that are not implemented read as 0, and writes to them have no effect.
- R10: `dev_reset` restores the R1 values at the next edge. If a configuration write arrives in the same cycle, the reset wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_reset | input | 1 | Synchronous device reset pulse |
| cfg_idx | input | 8 | Configuration register index |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_rdata | output | 8 | Configuration read data, registered |
| bus_rd | input | 1 | System-bus I/O read strobe |
| bus_addr | input | 16 | System-bus I/O address |
| bus_drive | output | 1 | Responder drives the bus this cycle |
| bus_rdata | output | 8 | Test byte, or 0 when not driving |
| dev_active | output | 1 | Device activated |

## Verification
Each result arrives one clock edge after its stimulus. The same applies to a register write reaching `dev_active`, to a configuration read reaching `cfg_rdata`, and to a bus read reaching `bus_drive`/`bus_rdata`. The bench drives stimulus on the falling edge and records at the next rising edge that a request was taken. It then compares outputs at the falling edge that follows, so every sample lands half a period after the register that produces it. Requests and expected values pass through a queue in issue order. This lets a configuration read and a bus read be checked by one monitor without any knowledge of internal state.

// File: rtl/ldev_pkg.sv
package ldev_pkg;

   localparam logic [7:0] IDX_ACT   = 8'h30;
   localparam logic [7:0] IDX_RCHK  = 8'h31;
   localparam logic [7:0] IDX_IOB   = 8'h60;
   localparam logic [7:0] IDX_IRQ   = 8'h70;
   localparam logic [7:0] IDX_DMA   = 8'h74;

   localparam logic [2:0] DMA_NONE  = 3'd4;
   localparam logic [7:0] PAT_55    = 8'h55;
   localparam logic [7:0] PAT_AA    = 8'hAA;

   typedef struct packed {
      logic en;      // range check enabled
      logic sel55;   // 1: answer 0x55, 0: answer 0xAA
   } rchk_t;

endpackage

// File: rtl/ldev_cfg_regs.sv
module ldev_cfg_regs
   import ldev_pkg::*;
#(
   parameter int unsigned NUM_IO        = 8,
   parameter int unsigned NUM_IRQ       = 2,
   parameter int unsigned NUM_DMA       = 2,
   parameter bit          IRQ_TYPE_RO   = 1'b0,
   parameter logic [1:0]  IRQ_TYPE_INIT = 2'b10
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         dev_reset,
   input  logic [7:0]                   cfg_idx,
   input  logic                         cfg_wr,
   input  logic [7:0]                   cfg_wdata,
   input  logic                         cfg_rd,
   output logic [7:0]                   cfg_rdata,
   output logic                         act_o,
   output rchk_t                        chk_o,
   output logic [NUM_IO-1:0][15:0]      io_base_o
);

   logic                      act_q;
   rchk_t                     chk_q;
   logic [NUM_IO-1:0][15:0]   iob_q;
   logic [NUM_IRQ-1:0][3:0]   irq_lvl_q;
   logic [NUM_IRQ-1:0][1:0]   irq_typ;
   logic [NUM_DMA-1:0][2:0]   dma_q;
   logic [7:0]                rd_val;

   // activation
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               act_q <= 1'b0;
      else if (dev_reset)                       act_q <= 1'b0;
      else if (cfg_wr && cfg_idx == IDX_ACT)    act_q <= cfg_wdata[0];
   end

   // range-check control
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               chk_q <= '0;
      else if (dev_reset)                       chk_q <= '0;
      else if (cfg_wr && cfg_idx == IDX_RCHK) begin
         chk_q.en    <= cfg_wdata[1];
         chk_q.sel55 <= cfg_wdata[0];
      end
   end

   // I/O base windows: high byte first, low byte second
   for (genvar i = 0; i < NUM_IO; i++) begin : g_iob
      localparam logic [7:0] HI_IDX = IDX_IOB + 8'(2 * i);
      localparam logic [7:0] LO_IDX = IDX_IOB + 8'(2 * i + 1);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              iob_q[i] <= '0;
         else if (dev_reset)                      iob_q[i] <= '0;
         else if (cfg_wr && cfg_idx == HI_IDX)    iob_q[i][15:8] <= cfg_wdata;
         else if (cfg_wr && cfg_idx == LO_IDX)    iob_q[i][7:0]  <= cfg_wdata;
      end
   end

   // interrupt entries
   for (genvar j = 0; j < NUM_IRQ; j++) begin : g_irq
      localparam logic [7:0] LVL_IDX = IDX_IRQ + 8'(2 * j);
      localparam logic [7:0] TYP_IDX = IDX_IRQ + 8'(2 * j + 1);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              irq_lvl_q[j] <= '0;
         else if (dev_reset)                      irq_lvl_q[j] <= '0;
         else if (cfg_wr && cfg_idx == LVL_IDX)   irq_lvl_q[j] <= cfg_wdata[3:0];
      end
      if (IRQ_TYPE_RO) begin : g_typ_fixed
         assign irq_typ[j] = IRQ_TYPE_INIT;
      end else begin : g_typ_rw
         logic [1:0] typ_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                            typ_q <= IRQ_TYPE_INIT;
            else if (dev_reset)                    typ_q <= IRQ_TYPE_INIT;
            else if (cfg_wr && cfg_idx == TYP_IDX) typ_q <= cfg_wdata[1:0];
         end
         assign irq_typ[j] = typ_q;
      end
   end

   // DMA selectors
   for (genvar k = 0; k < NUM_DMA; k++) begin : g_dma
      localparam logic [7:0] SEL_IDX = IDX_DMA + 8'(k);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              dma_q[k] <= DMA_NONE;
         else if (dev_reset)                      dma_q[k] <= DMA_NONE;
         else if (cfg_wr && cfg_idx == SEL_IDX)   dma_q[k] <= cfg_wdata[2:0];
      end
   end

   // read-back multiplexer
   always_comb begin
      rd_val = 8'h00;
      if (cfg_idx == IDX_ACT)  rd_val = {7'b0, act_q};
      if (cfg_idx == IDX_RCHK) rd_val = {6'b0, chk_q.en, chk_q.sel55};
      for (int i = 0; i < NUM_IO; i++) begin
         if (cfg_idx == IDX_IOB + 8'(2 * i))     rd_val = iob_q[i][15:8];
         if (cfg_idx == IDX_IOB + 8'(2 * i + 1)) rd_val = iob_q[i][7:0];
      end
      for (int j = 0; j < NUM_IRQ; j++) begin
         if (cfg_idx == IDX_IRQ + 8'(2 * j))     rd_val = {4'b0, irq_lvl_q[j]};
         if (cfg_idx == IDX_IRQ + 8'(2 * j + 1)) rd_val = {6'b0, irq_typ[j]};
      end
      for (int k = 0; k < NUM_DMA; k++) begin
         if (cfg_idx == IDX_DMA + 8'(k))         rd_val = {5'b0, dma_q[k]};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_rdata <= 8'h00;
      else if (cfg_rd) cfg_rdata <= rd_val;
   end

   assign act_o     = act_q;
   assign chk_o     = chk_q;
   assign io_base_o = iob_q;

endmodule

// File: rtl/ldev_io_match.sv
module ldev_io_match #(
   parameter int unsigned           NUM_IO   = 8,
   parameter logic [NUM_IO*8-1:0]   IO_SPANS = {NUM_IO{8'd8}}
) (
   input  logic [15:0]              addr,
   input  logic [NUM_IO-1:0][15:0]  bases,
   output logic                     hit
);

   logic [NUM_IO-1:0] hit_v;

   for (genvar i = 0; i < NUM_IO; i++) begin : g_win
      localparam logic [16:0] SPAN = {9'b0, IO_SPANS[i*8 +: 8]};
      logic [16:0] lo_b;
      logic [16:0] hi_b;
      logic [16:0] a17;
      assign lo_b     = {1'b0, bases[i]};
      assign hi_b     = lo_b + SPAN;
      assign a17      = {1'b0, addr};
      assign hit_v[i] = (bases[i] != 16'h0000) && (a17 >= lo_b) && (a17 < hi_b);
   end

   assign hit = |hit_v;

endmodule

// File: rtl/ldev_rchk_resp.sv
module ldev_rchk_resp
   import ldev_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_rd,
   input  logic       hit,
   input  logic       act,
   input  rchk_t      chk,
   output logic       bus_drive,
   output logic [7:0] bus_rdata
);

   logic answer;
   assign answer = bus_rd && hit && chk.en && !act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_drive <= 1'b0;
         bus_rdata <= 8'h00;
      end else begin
         bus_drive <= answer;
         bus_rdata <= answer ? (chk.sel55 ? PAT_55 : PAT_AA) : 8'h00;
      end
   end

endmodule

// File: rtl/ldev_iochk.sv
module ldev_iochk
   import ldev_pkg::*;
#(
   parameter int unsigned           NUM_IO        = 8,
   parameter int unsigned           NUM_IRQ       = 2,
   parameter int unsigned           NUM_DMA       = 2,
   parameter logic [NUM_IO*8-1:0]   IO_SPANS      = {NUM_IO{8'd8}},
   parameter bit                    IRQ_TYPE_RO   = 1'b0,
   parameter logic [1:0]            IRQ_TYPE_INIT = 2'b10
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        dev_reset,
   input  logic [7:0]  cfg_idx,
   input  logic        cfg_wr,
   input  logic [7:0]  cfg_wdata,
   input  logic        cfg_rd,
   output logic [7:0]  cfg_rdata,
   input  logic        bus_rd,
   input  logic [15:0] bus_addr,
   output logic        bus_drive,
   output logic [7:0]  bus_rdata,
   output logic        dev_active
);

   // elaboration-time parameter checks
   if (NUM_IO < 1 || NUM_IO > 8) begin : g_bad_io
      $error("ldev_iochk: NUM_IO must be 1..8");
   end
   if (NUM_IRQ < 1 || NUM_IRQ > 2) begin : g_bad_irq
      $error("ldev_iochk: NUM_IRQ must be 1..2");
   end
   if (NUM_DMA < 1 || NUM_DMA > 2) begin : g_bad_dma
      $error("ldev_iochk: NUM_DMA must be 1..2");
   end
   for (genvar i = 0; i < NUM_IO; i++) begin : g_span_chk
      if (IO_SPANS[i*8 +: 8] == 8'd0) begin : g_bad_span
         $error("ldev_iochk: every window span must be non-zero");
      end
   end

   logic                     act_w;
   rchk_t                    chk_w;
   logic                     chk_en_w;
   logic [NUM_IO-1:0][15:0]  bases_w;
   logic                     hit_w;

   ldev_cfg_regs #(
      .NUM_IO        (NUM_IO),
      .NUM_IRQ       (NUM_IRQ),
      .NUM_DMA       (NUM_DMA),
      .IRQ_TYPE_RO   (IRQ_TYPE_RO),
      .IRQ_TYPE_INIT (IRQ_TYPE_INIT)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .dev_reset (dev_reset),
      .cfg_idx   (cfg_idx),
      .cfg_wr    (cfg_wr),
      .cfg_wdata (cfg_wdata),
      .cfg_rd    (cfg_rd),
      .cfg_rdata (cfg_rdata),
      .act_o     (act_w),
      .chk_o     (chk_w),
      .io_base_o (bases_w)
   );

   ldev_io_match #(
      .NUM_IO   (NUM_IO),
      .IO_SPANS (IO_SPANS)
   ) u_match (
      .addr  (bus_addr),
      .bases (bases_w),
      .hit   (hit_w)
   );

   ldev_rchk_resp u_resp (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_rd    (bus_rd),
      .hit       (hit_w),
      .act       (act_w),
      .chk       (chk_w),
      .bus_drive (bus_drive),
      .bus_rdata (bus_rdata)
   );

   assign chk_en_w   = chk_w.en;
   assign dev_active = act_w;

endmodule

// File: rtl/ldev_iochk_chk.sv
module ldev_iochk_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       dev_reset,
   input logic       cfg_rd,
   input logic [7:0] cfg_rdata,
   input logic       bus_rd,
   input logic       bus_drive,
   input logic [7:0] bus_rdata,
   input logic       dev_active,
   input logic       chk_en
);

   // R7: a drive only ever follows a bus read
   assert_drive_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_drive |-> $past(bus_rd));

   // R7: driven byte is one of the two test patterns
   assert_pattern_R7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_drive |-> (bus_rdata == 8'h55 || bus_rdata == 8'hAA));

   // R7: quiet bus data when not driving
   assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_drive |-> (bus_rdata == 8'h00));

   // R8: only inactive, check-enabled devices answer
   assert_inactive_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_drive |-> (!$past(dev_active) && $past(chk_en)));

   // R10: device reset clears activation
   assert_reset_deact_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(dev_reset) |-> !dev_active);

   // R9: read data holds between reads
   assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cfg_rd) |-> $stable(cfg_rdata));

endmodule

bind ldev_iochk ldev_iochk_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .dev_reset  (dev_reset),
   .cfg_rd     (cfg_rd),
   .cfg_rdata  (cfg_rdata),
   .bus_rd     (bus_rd),
   .bus_drive  (bus_drive),
   .bus_rdata  (bus_rdata),
   .dev_active (dev_active),
   .chk_en     (chk_en_w)
);

// File: tb/ldev_iochk_tb.sv
module ldev_iochk_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dev_reset = 1'b0;
   logic [7:0]  cfg_idx = 8'h00;
   logic        cfg_wr = 1'b0;
   logic [7:0]  cfg_wdata = 8'h00;
   logic        cfg_rd = 1'b0;
   logic [7:0]  cfg_rdata;
   logic        bus_rd = 1'b0;
   logic [15:0] bus_addr = 16'h0000;
   logic        bus_drive;
   logic [7:0]  bus_rdata;
   logic        dev_active;

   int n_cmp = 0;
   int n_bad = 0;

   typedef struct {
      bit         is_bus;
      bit         drive;
      logic [7:0] data;
      string      tag;
   } exp_t;

   exp_t exp_q[$];
   bit   seen = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   ldev_iochk u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .dev_reset  (dev_reset),
      .cfg_idx    (cfg_idx),
      .cfg_wr     (cfg_wr),
      .cfg_wdata  (cfg_wdata),
      .cfg_rd     (cfg_rd),
      .cfg_rdata  (cfg_rdata),
      .bus_rd     (bus_rd),
      .bus_addr   (bus_addr),
      .bus_drive  (bus_drive),
      .bus_rdata  (bus_rdata),
      .dev_active (dev_active)
   );

   task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // monitor: request taken at a rising edge, compared at the next falling edge
   always @(posedge clk) seen <= cfg_rd | bus_rd;

   initial begin
      forever begin
         @(negedge clk);
         if (seen && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            if (e.is_bus) begin
               check({e.tag, " drive"}, {15'b0, bus_drive}, {15'b0, e.drive});
               check({e.tag, " data"},  {8'b0, bus_rdata},  {8'b0, e.data});
            end else begin
               check(e.tag, {8'b0, cfg_rdata}, {8'b0, e.data});
            end
         end
      end
   end

   task automatic cfg_write(logic [7:0] idx, logic [7:0] d);
      cfg_idx = idx; cfg_wdata = d; cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic cfg_read(logic [7:0] idx, logic [7:0] exp, string tag);
      exp_t e;
      e.is_bus = 1'b0; e.drive = 1'b0; e.data = exp; e.tag = tag;
      exp_q.push_back(e);
      cfg_idx = idx; cfg_rd = 1'b1;
      @(negedge clk);
      cfg_rd = 1'b0;
   endtask

   task automatic io_read(logic [15:0] a, bit drv, logic [7:0] exp, string tag);
      exp_t e;
      e.is_bus = 1'b1; e.drive = drv; e.data = drv ? exp : 8'h00; e.tag = tag;
      exp_q.push_back(e);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(20 * 100000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check("R1 active",    {15'b0, dev_active}, 16'h0);
      check("R1 drive",     {15'b0, bus_drive},  16'h0);
      check("R1 bus data",  {8'b0, bus_rdata},   16'h0);
      cfg_read(8'h30, 8'h00, "R1 act");
      cfg_read(8'h31, 8'h00, "R1 rchk");
      cfg_read(8'h6E, 8'h00, "R1 base7 hi");
      cfg_read(8'h71, 8'h02, "R1 irq0 type");
      cfg_read(8'h74, 8'h04, "R6 dma0 none");
      cfg_read(8'h75, 8'h04, "R6 dma1 none");

      // R4: program windows 0 and 2
      cfg_write(8'h60, 8'h03); cfg_write(8'h61, 8'h40);
      cfg_write(8'h64, 8'h02); cfg_write(8'h65, 8'h20);
      cfg_read(8'h60, 8'h03, "R4 base0 hi");
      cfg_read(8'h61, 8'h40, "R4 base0 lo");
      cfg_read(8'h65, 8'h20, "R4 base2 lo");

      // R3: range-check control
      cfg_write(8'h31, 8'hFF);
      cfg_read(8'h31, 8'h03, "R3 upper bits zero");
      cfg_write(8'h31, 8'h03);

      // R7: hits and edges with 0x55
      io_read(16'h0340, 1'b1, 8'h55, "R7 base0 first");
      io_read(16'h0347, 1'b1, 8'h55, "R7 base0 last");
      io_read(16'h0348, 1'b0, 8'h00, "R8 past end");
      io_read(16'h033F, 1'b0, 8'h00, "R8 below base");
      io_read(16'h0225, 1'b1, 8'h55, "R7 base2 mid");
      io_read(16'h0003, 1'b0, 8'h00, "R7 zero base off");

      // R7: 0xAA pattern
      cfg_write(8'h31, 8'h02);
      io_read(16'h0341, 1'b1, 8'hAA, "R7 pattern AA");

      // R2 / R8: activation blocks responder
      cfg_write(8'h30, 8'hFF);
      check("R2 dev_active", {15'b0, dev_active}, 16'h1);
      cfg_read(8'h30, 8'h01, "R2 readback");
      io_read(16'h0341, 1'b0, 8'h00, "R8 active");
      cfg_write(8'h30, 8'h00);
      check("R2 deactivate", {15'b0, dev_active}, 16'h0);
      io_read(16'h0342, 1'b1, 8'hAA, "R7 inactive again");

      // R8: check disabled
      cfg_write(8'h31, 8'h01);
      io_read(16'h0342, 1'b0, 8'h00, "R8 check off");

      // R5: interrupt entries
      cfg_write(8'h70, 8'hFA); cfg_read(8'h70, 8'h0A, "R5 level0");
      cfg_write(8'h71, 8'hFF); cfg_read(8'h71, 8'h03, "R5 type0");
      cfg_write(8'h72, 8'h05); cfg_read(8'h72, 8'h05, "R5 level1");

      // R6: DMA selectors
      cfg_write(8'h74, 8'hFE); cfg_read(8'h74, 8'h06, "R6 dma0");
      cfg_write(8'h75, 8'h01); cfg_read(8'h75, 8'h01, "R6 dma1");

      // R9: unimplemented indices, hold between reads
      cfg_write(8'h50, 8'h77); cfg_read(8'h50, 8'h00, "R9 unimpl 50");
      cfg_write(8'h76, 8'h33); cfg_read(8'h76, 8'h00, "R9 unimpl 76");
      cfg_read(8'h61, 8'h40, "R9 base0 lo");
      cfg_idx = 8'h30;
      repeat (3) @(negedge clk);
      check("R9 hold", {8'b0, cfg_rdata}, 16'h0040);

      // R10: device reset wins over simultaneous write
      cfg_write(8'h31, 8'h02);
      cfg_idx = 8'h30; cfg_wdata = 8'h01; cfg_wr = 1'b1; dev_reset = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0; dev_reset = 1'b0;
      check("R10 active cleared", {15'b0, dev_active}, 16'h0);
      cfg_read(8'h30, 8'h00, "R10 act");
      cfg_read(8'h31, 8'h00, "R10 rchk");
      cfg_read(8'h60, 8'h00, "R10 base0");
      cfg_read(8'h70, 8'h00, "R10 level0");
      cfg_read(8'h71, 8'h02, "R10 type0");
      cfg_read(8'h74, 8'h04, "R10 dma0");
      io_read(16'h0340, 1'b0, 8'h00, "R10 no drive");

      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule